// File: doc/BRIEF.md
# SPI Potentiometer Command Decoder

This block is the serial front end of a digitally controlled potentiometer. It acts as a mode-0 SPI target. It oversamples the select, clock, data and pause pins in the system clock domain. It frames each transaction, checks the identification byte against a fixed device-type nibble and two strapped address pins, and decodes the instruction byte. It then either collects a 10-bit payload, shifts a 10-bit value out, or returns the write-in-progress flag.

The block holds no register contents. Register reads, writes and transfers go out as single-cycle requests to a separate register bank: a kind code, a slot index and, for writes, the payload. Read data comes back on a parallel input. Writes and transfers are committed only when the select line is released on the exact frame boundary. Reads are requested as soon as the instruction byte is complete, so the data can be serialized in the bytes that follow.

Top module: `spi_pot_cmd`

## Requirements
- R1: After reset, `spi_sdo_oe`, `spi_sdo` and `bank_req_valid` are all low.
- R2: Byte 1 (MSB first) must be `0101`, then `0`, then two address bits equal to `dev_addr`, then a read flag in the LSB (1 = read). Any mismatch discards the whole frame: no request and no output enable.
- R3: A 32-bit frame with instruction byte `100_0_00_00` and read flag 0 issues one request of kind 1 (write wiper) when select rises. Its data is the low 10 bits of bytes 3–4; the upper six bits are ignored. `bank_req_valid` is high for exactly one clock.
- R4: The same frame with instruction `101_0_ss_00` and read flag 0 issues kind 3 (write slot) with index `ss` (bits 3:2 of byte 2).
- R5: 16-bit frames with instruction `110_0_ss_00` or `111_0_ss_00` issue kind 4 (slot to wiper) or kind 5 (wiper to slot) with index `ss`, whatever the read flag.
- R6: A write or transfer is issued only if select rises after exactly 32 (writes) or 16 (transfers) bits. A shorter or longer frame issues nothing.
- R7: Instructions `100` and `101` with read flag 1 issue kind 0 (read wiper) or kind 2 (read slot) when byte 2 completes. `bank_rd_data` must be valid from the second clock after that pulse. Bytes 3–4 then carry six zeros and the 10-bit value, MSB first. SO changes on falling SCK and `spi_sdo_oe` is high during these bytes.
- R8: Instruction `010` is a 32-bit status read. Byte 3 is zero and byte 4 is seven zeros followed by `bank_busy`.
- R9: HOLD falling while SCK is low pauses the frame. SCK edges are ignored and `spi_sdo_oe` is low until HOLD rises while SCK is low. The frame then resumes at the same bit position.
- R10: Any other instruction opcode discards the frame silently.
- R11: After reset, no frame is accepted until select has fallen at least once.
- R12: While select is high, `spi_sdo_oe` is low and the frame state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Target select, active low |
| spi_sck | input | 1 | Serial clock, slower than clk/4 |
| spi_sdi | input | 1 | Serial data in, sampled on rising SCK |
| spi_hold_n | input | 1 | Pause request, active low |
| dev_addr | input | 2 | Strapped device address |
| spi_sdo | output | 1 | Serial data out, changes on falling SCK |
| spi_sdo_oe | output | 1 | Output enable for the SO pad driver |
| bank_req_valid | output | 1 | One-clock request strobe |
| bank_req_kind | output | 3 | 0 rd wiper, 1 wr wiper, 2 rd slot, 3 wr slot, 4 slot→wiper, 5 wiper→slot |
| bank_req_idx | output | 2 | Data slot index |
| bank_req_data | output | 10 | Write payload |
| bank_rd_data | input | 10 | Read data returned by the bank |
| bank_busy | input | 1 | Write-in-progress flag for status reads |

## Verification
A pin change is taken into two synchronizer flops and acted on by a register, so the effect shows after the third clock edge. A select rise yields its request three clocks later, and a falling SCK moves SO three clocks later. The bench holds each SCK phase for six clocks and samples SO just before it raises SCK. It waits ten clocks after releasing select before closing a frame's checks. Requests are compared on the opposite clock edge against a queue of expected requests, and any unexpected strobe is a failure.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
  localparam int BYTE_BITS  = 8;
  localparam int SHORT_BITS = 2 * BYTE_BITS;
  localparam int LONG_BITS  = 4 * BYTE_BITS;
  localparam int PAY_BITS   = 2 * BYTE_BITS;

  localparam logic [3:0] DEV_TYPE = 4'b0101;

  localparam logic [2:0] OP_WIPER  = 3'b100;
  localparam logic [2:0] OP_SLOT   = 3'b101;
  localparam logic [2:0] OP_S2W    = 3'b110;
  localparam logic [2:0] OP_W2S    = 3'b111;
  localparam logic [2:0] OP_STATUS = 3'b010;

  typedef enum logic [2:0] {
    KIND_RD_WIPER = 3'd0,
    KIND_WR_WIPER = 3'd1,
    KIND_RD_SLOT  = 3'd2,
    KIND_WR_SLOT  = 3'd3,
    KIND_S2W      = 3'd4,
    KIND_W2S      = 3'd5
  } req_kind_e;
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_pot_tx.sv
module spi_pot_tx import spi_pot_pkg::*; #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift,
  input  logic              status_sel,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              busy,
  output logic              sdo
);
  logic [PAY_BITS-1:0] tx_sr;
  logic [PAY_BITS-1:0] word;
  logic                started;

  assign word = status_sel ? {{(PAY_BITS-1){1'b0}}, busy}
                           : {{(PAY_BITS-DATA_W){1'b0}}, rd_data};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      tx_sr   <= '0;
      started <= 1'b0;
      sdo     <= 1'b0;
    end else if (shift) begin
      if (!started) begin
        sdo     <= word[PAY_BITS-1];
        tx_sr   <= {word[PAY_BITS-2:0], 1'b0};
        started <= 1'b1;
      end else begin
        sdo   <= tx_sr[PAY_BITS-1];
        tx_sr <= {tx_sr[PAY_BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_pot_ctrl.sv
module spi_pot_ctrl import spi_pot_pkg::*; #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              sck_lvl,
  input  logic              si_lvl,
  input  logic              hold_lvl,
  input  logic [1:0]        dev_addr,
  output logic              req_valid,
  output logic [2:0]        req_kind,
  output logic [1:0]        req_idx,
  output logic [DATA_W-1:0] req_data,
  output logic              tx_shift,
  output logic              tx_status_sel,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(LONG_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(LONG_BITS + 1);
  localparam logic [CNT_W-1:0] ID_LAST    = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] INS_LAST   = CNT_W'(SHORT_BITS - 1);
  localparam logic [CNT_W-1:0] SHORT_DONE = CNT_W'(SHORT_BITS);
  localparam logic [CNT_W-1:0] LONG_DONE  = CNT_W'(LONG_BITS);

  logic cs_q, sck_q, hold_q;
  logic cs_fall, cs_rise, sck_rise, sck_fall, hold_fall, hold_rise;
  logic active, paused, aborted, rd_phase, wr_pending, long_fmt, rw;
  logic [CNT_W-1:0]    bitcnt;
  logic [PAY_BITS-1:0] rx_sr, rx_next;
  logic [7:0]          cur_byte;
  logic                id_ok, frame_exact, shift_ok;

  // edge detection on the synchronized levels
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b0;
      sck_q  <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      cs_q   <= cs_lvl;
      sck_q  <= sck_lvl;
      hold_q <= hold_lvl;
    end
  end

  assign cs_fall   = !cs_lvl && cs_q;
  assign cs_rise   = cs_lvl && !cs_q;
  assign sck_rise  = sck_lvl && !sck_q;
  assign sck_fall  = !sck_lvl && sck_q;
  assign hold_fall = !hold_lvl && hold_q;
  assign hold_rise = hold_lvl && !hold_q;

  assign rx_next     = {rx_sr[PAY_BITS-2:0], si_lvl};
  assign cur_byte    = rx_next[7:0];
  assign id_ok       = (cur_byte[7:4] == DEV_TYPE) && !cur_byte[3] && (cur_byte[2:1] == dev_addr);
  assign frame_exact = long_fmt ? (bitcnt == LONG_DONE) : (bitcnt == SHORT_DONE);
  assign shift_ok    = active && !paused && !aborted && !cs_lvl && sck_rise;
  assign tx_shift    = active && !paused && rd_phase && !cs_lvl && sck_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      active        <= 1'b0;
      paused        <= 1'b0;
      aborted       <= 1'b0;
      rd_phase      <= 1'b0;
      wr_pending    <= 1'b0;
      long_fmt      <= 1'b0;
      rw            <= 1'b0;
      bitcnt        <= '0;
      rx_sr         <= '0;
      req_valid     <= 1'b0;
      req_kind      <= KIND_RD_WIPER;
      req_idx       <= '0;
      req_data      <= '0;
      tx_status_sel <= 1'b0;
      sdo_oe        <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      sdo_oe    <= !cs_lvl && active && rd_phase && !paused;
      if (cs_lvl) begin
        // commit a write or transfer only on an exact frame boundary
        if (cs_rise && active && !aborted && wr_pending && frame_exact) begin
          req_valid <= 1'b1;
          req_data  <= rx_sr[DATA_W-1:0];
        end
        active     <= 1'b0;
        paused     <= 1'b0;
        aborted    <= 1'b0;
        rd_phase   <= 1'b0;
        wr_pending <= 1'b0;
        bitcnt     <= '0;
      end else if (cs_fall) begin
        active <= 1'b1;
        bitcnt <= '0;
      end else if (active) begin
        if (!paused && hold_fall && !sck_lvl)      paused <= 1'b1;
        else if (paused && hold_rise && !sck_lvl)  paused <= 1'b0;
        if (shift_ok) begin
          rx_sr <= rx_next;
          if (bitcnt != CNT_SAT) bitcnt <= bitcnt + 1'b1;
          if (bitcnt == ID_LAST) begin
            rw <= cur_byte[0];
            if (!id_ok) aborted <= 1'b1;
          end
          if (bitcnt == INS_LAST) begin
            req_idx <= cur_byte[3:2];
            case (cur_byte[7:5])
              OP_WIPER, OP_SLOT: begin
                long_fmt <= 1'b1;
                if (rw) begin
                  req_kind      <= (cur_byte[5]) ? KIND_RD_SLOT : KIND_RD_WIPER;
                  req_valid     <= 1'b1;
                  rd_phase      <= 1'b1;
                  tx_status_sel <= 1'b0;
                end else begin
                  req_kind   <= (cur_byte[5]) ? KIND_WR_SLOT : KIND_WR_WIPER;
                  wr_pending <= 1'b1;
                end
              end
              OP_S2W, OP_W2S: begin
                long_fmt   <= 1'b0;
                req_kind   <= (cur_byte[5]) ? KIND_W2S : KIND_S2W;
                wr_pending <= 1'b1;
              end
              OP_STATUS: begin
                long_fmt      <= 1'b1;
                rd_phase      <= 1'b1;
                tx_status_sel <= 1'b1;
              end
              default: aborted <= 1'b1;
            endcase
          end
        end
      end
    end
  end

  assert_req_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  assert_no_req_after_bad_frame_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && aborted) |=> !req_valid);

  assert_no_commit_off_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && bitcnt != SHORT_DONE && bitcnt != LONG_DONE) |=> !req_valid);

  assert_pause_freezes_count_R9: assert property (@(posedge clk) disable iff (rst)
    (paused && sck_rise && !cs_lvl) |=> $stable(bitcnt));

  assert_oe_off_when_deselected_R12: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> !sdo_oe);

  assert_idle_until_select_R11: assert property (@(posedge clk) disable iff (rst)
    !active |=> !sdo_oe);
endmodule

// File: rtl/spi_pot_cmd.sv
module spi_pot_cmd import spi_pot_pkg::*; #(
  parameter int DATA_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  input  logic              spi_hold_n,
  input  logic [1:0]        dev_addr,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              bank_req_valid,
  output logic [2:0]        bank_req_kind,
  output logic [1:0]        bank_req_idx,
  output logic [DATA_W-1:0] bank_req_data,
  input  logic [DATA_W-1:0] bank_rd_data,
  input  logic              bank_busy
);
  localparam int PIN_W = 4;
  localparam logic [PIN_W-1:0] PIN_RST = 4'b1000;

  logic [PIN_W-1:0] pins_s;
  logic             tx_shift, tx_status_sel;

  spi_pot_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({spi_hold_n, spi_sdi, spi_sck, spi_cs_n}),
    .dout(pins_s)
  );

  spi_pot_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cs_lvl       (pins_s[0]),
    .sck_lvl      (pins_s[1]),
    .si_lvl       (pins_s[2]),
    .hold_lvl     (pins_s[3]),
    .dev_addr     (dev_addr),
    .req_valid    (bank_req_valid),
    .req_kind     (bank_req_kind),
    .req_idx      (bank_req_idx),
    .req_data     (bank_req_data),
    .tx_shift     (tx_shift),
    .tx_status_sel(tx_status_sel),
    .sdo_oe       (spi_sdo_oe)
  );

  spi_pot_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .clear     (pins_s[0]),
    .shift     (tx_shift),
    .status_sel(tx_status_sel),
    .rd_data   (bank_rd_data),
    .busy      (bank_busy),
    .sdo       (spi_sdo)
  );
endmodule

// File: tb/test_spi_pot_cmd.sv
module test_spi_pot_cmd;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       cs_n = 1'b0, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic [1:0] straps = 2'b10;
  logic [9:0] rd_data = '0;
  logic       busy = 1'b0;
  logic       sdo, sdo_oe, req_valid;
  logic [2:0] req_kind;
  logic [1:0] req_idx;
  logic [9:0] req_data;

  spi_pot_cmd i_spi_pot_cmd (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
    .spi_hold_n(hold_n), .dev_addr(straps), .spi_sdo(sdo), .spi_sdo_oe(sdo_oe),
    .bank_req_valid(req_valid), .bank_req_kind(req_kind), .bank_req_idx(req_idx),
    .bank_req_data(req_data), .bank_rd_data(rd_data), .bank_busy(busy)
  );

  int          checks = 0, errors = 0, req_seen = 0;
  string       cur_req = "R1";
  logic [15:0] exp_q[$];
  logic [9:0]  wcr_m = '0;
  logic [9:0]  dr_m [4];
  logic        pause_oe = 1'b0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit hd, input logic [2:0] k, input logic [1:0] ix, input logic [9:0] d);
    return {hd, k, ix, d};
  endfunction

  function automatic logic [7:0] idb(input logic [3:0] ty, input logic [1:0] a, input logic rw);
    return {ty, 1'b0, a, rw};
  endfunction

  // register bank stand-in: registered read data
  always @(posedge clk) begin
    if (req_valid && req_kind == 3'd0) rd_data <= wcr_m;
    else if (req_valid && req_kind == 3'd2) rd_data <= dr_m[req_idx];
  end

  // request monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      req_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_req, " unexpected request"}, {23'd0, req_kind, req_idx, 4'd0}, 32'd0);
      end else begin
        logic [15:0] e, a;
        e = exp_q.pop_front();
        a = {e[15], req_kind, req_idx, e[15] ? req_data : 10'd0};
        chk(a == e, {cur_req, " request"}, a, e);
      end
    end
  end

  task automatic xfer(input logic [47:0] bits, input int n, input int pause_at,
                      output logic [15:0] tail, output logic oe_last);
    tail = '0;
    oe_last = 1'b0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i == pause_at) begin
        hold_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b1; repeat (HALF) @(negedge clk);
          sdi = ~sdi; sck = 1'b0; repeat (HALF) @(negedge clk);
        end
        pause_oe = sdo_oe;
        hold_n = 1'b1;
        repeat (HALF) @(negedge clk);
      end
      sdi = bits[n-1-i];
      repeat (HALF) @(negedge clk);
      tail = {tail[14:0], sdo};
      oe_last = sdo_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, 200000, 0);
    finish_run();
  end

  initial begin
    logic [15:0] tail;
    logic        oe;
    int          seen0;
    logic [31:0] wr_w;
    logic [15:0] xf;
    for (int i = 0; i < 4; i++) dr_m[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    cur_req = "R1";
    chk(sdo_oe == 1'b0, "R1 oe", {31'd0, sdo_oe}, 0);
    chk(sdo == 1'b0, "R1 sdo", {31'd0, sdo}, 0);
    chk(req_valid == 1'b0, "R1 req", {31'd0, req_valid}, 0);

    // R11: select held low through reset, full frame clocked with no falling select
    cur_req = "R11";
    seen0 = req_seen;
    wr_w = {idb(4'b0101, 2'b10, 1'b0), 8'h80, 6'b0, 10'h2A5};
    for (int i = 0; i < 32; i++) begin
      sdi = wr_w[31-i];
      repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(req_seen == seen0, "R11 no request before select fall", req_seen, seen0);

    cur_req = "R3";
    exp_q.push_back(mk(1, 3'd1, 2'd0, 10'h2A5));
    xfer({16'd0, wr_w}, 32, -1, tail, oe);
    chk(exp_q.size() == 0, "R3 write wiper issued", exp_q.size(), 0);
    chk(oe == 1'b0, "R3 no oe on write", {31'd0, oe}, 0);

    cur_req = "R4";
    exp_q.push_back(mk(1, 3'd3, 2'd2, 10'h3FF));
    xfer({16'd0, idb(4'b0101, 2'b10, 1'b0), 8'hA8, 6'b111111, 10'h3FF}, 32, -1, tail, oe);
    chk(exp_q.size() == 0, "R4 write slot issued", exp_q.size(), 0);

    cur_req = "R5";
    exp_q.push_back(mk(1'b0, 3'd4, 2'd3, 10'd0));
    xfer({32'd0, idb(4'b0101, 2'b10, 1'b0), 8'hCC}, 16, -1, tail, oe);
    exp_q.push_back(mk(1'b0, 3'd5, 2'd1, 10'd0));
    xfer({32'd0, idb(4'b0101, 2'b10, 1'b1), 8'hE4}, 16, -1, tail, oe);
    chk(exp_q.size() == 0, "R5 transfers issued", exp_q.size(), 0);

    cur_req = "R6";
    seen0 = req_seen;
    xfer({16'd0, wr_w >> 1}, 31, -1, tail, oe);
    xfer({8'd0, wr_w, 8'h55}, 40, -1, tail, oe);
    xf = {idb(4'b0101, 2'b10, 1'b0), 8'hCC};
    xfer({24'd0, xf, 8'h00}, 24, -1, tail, oe);
    chk(req_seen == seen0, "R6 partial or overlong frames", req_seen, seen0);

    cur_req = "R2";
    seen0 = req_seen;
    xfer({16'd0, idb(4'b0100, 2'b10, 1'b0), 8'h80, 16'h0123}, 32, -1, tail, oe);
    xfer({16'd0, idb(4'b0101, 2'b01, 1'b0), 8'h80, 16'h0123}, 32, -1, tail, oe);
    xfer({16'd0, idb(4'b0101, 2'b11, 1'b1), 8'h80, 16'h0000}, 32, -1, tail, oe);
    chk(req_seen == seen0, "R2 mismatched id ignored", req_seen, seen0);
    chk(oe == 1'b0, "R2 no oe on mismatched read", {31'd0, oe}, 0);

    cur_req = "R10";
    seen0 = req_seen;
    xfer({16'd0, idb(4'b0101, 2'b10, 1'b0), 8'h60, 16'h0055}, 32, -1, tail, oe);
    xfer({16'd0, idb(4'b0101, 2'b10, 1'b1), 8'h00, 16'h0000}, 32, -1, tail, oe);
    chk(req_seen == seen0, "R10 unknown opcode ignored", req_seen, seen0);
    chk(oe == 1'b0, "R10 no oe", {31'd0, oe}, 0);

    cur_req = "R7";
    wcr_m = 10'h15A;
    exp_q.push_back(mk(1'b0, 3'd0, 2'd0, 10'd0));
    xfer({16'd0, idb(4'b0101, 2'b10, 1'b1), 8'h80, 16'h0000}, 32, -1, tail, oe);
    chk(tail == 16'h015A, "R7 read wiper data", tail, 16'h015A);
    chk(oe == 1'b1, "R7 oe during data", {31'd0, oe}, 1);
    chk(exp_q.size() == 0, "R7 read request", exp_q.size(), 0);
    dr_m[1] = 10'h2C3;
    exp_q.push_back(mk(1'b0, 3'd2, 2'd1, 10'd0));
    xfer({16'd0, idb(4'b0101, 2'b10, 1'b1), 8'hA4, 16'h0000}, 32, -1, tail, oe);
    chk(tail == 16'h02C3, "R7 read slot data", tail, 16'h02C3);

    cur_req = "R12";
    chk(sdo_oe == 1'b0, "R12 oe off after release", {31'd0, sdo_oe}, 0);

    cur_req = "R8";
    busy = 1'b1;
    xfer({16'd0, idb(4'b0101, 2'b10, 1'b1), 8'h40, 16'h0000}, 32, -1, tail, oe);
    chk(tail == 16'h0001, "R8 status busy", tail, 16'h0001);
    busy = 1'b0;
    xfer({16'd0, idb(4'b0101, 2'b10, 1'b1), 8'h40, 16'h0000}, 32, -1, tail, oe);
    chk(tail == 16'h0000, "R8 status idle", tail, 16'h0000);

    cur_req = "R9";
    exp_q.push_back(mk(1, 3'd3, 2'd0, 10'h1C7));
    xfer({16'd0, idb(4'b0101, 2'b10, 1'b0), 8'hA0, 6'b0, 10'h1C7}, 32, 12, tail, oe);
    chk(exp_q.size() == 0, "R9 write survives pause", exp_q.size(), 0);
    wcr_m = 10'h2F0;
    exp_q.push_back(mk(1'b0, 3'd0, 2'd0, 10'd0));
    xfer({16'd0, idb(4'b0101, 2'b10, 1'b1), 8'h80, 16'h0000}, 32, 22, tail, oe);
    chk(pause_oe == 1'b0, "R9 oe off while paused", {31'd0, pause_oe}, 0);
    chk(tail == 16'h02F0, "R9 read resumes in place", tail, 16'h02F0);
    chk(exp_q.size() == 0, "R9 read request", exp_q.size(), 0);

    finish_run();
  end
endmodule